// File: doc/BRIEF.md
# Synchronous Ethernet Port Quality Level Tracker

This block keeps the per-port clock quality state of a synchronous Ethernet line card. On the receive side, an upstream message decoder hands it one quality code per port with a valid strobe. For each port, the block holds the last usable code as that port's input level. A per-port seconds counter, driven by a shared one-second tick, returns the level to Unknown when messages stop arriving. From the input level and the port's synchronous-mode enable, the block derives whether the port may compete as a line clock input. Whenever a port's input level changes, it raises a one-cycle pulse so that reference selection runs again.

On the transmit side, the block takes the system clock quality level and a description of where the system reference comes from. It produces the level that each port's message builder must send. The port that supplies the reference sends Do-Not-Use, so that no timing loop forms. Every other port sends the system level.

Quality codes are 3 bits wide, and a lower code means a better clock: 0 primary reference, 1 primary-level supply unit, 2 second-level supply unit, 3 equipment clock, 4 Do-Not-Use, 5 Unknown. Codes 6 and 7 are not defined.

Top module: `synce_ql_tracker`

## Requirements
- R1: While rst_ni is low, every port shows input level 5 (Unknown), eligibility 0, update pulse 0 and transmit level 4 (Do-Not-Use).
- R2: On a port with sync_en_i high, a strobe carrying a code from 0 to 4 makes that code the port's input level, visible in the cycle after the strobe, and loads the port's timer with TIMEOUT_S seconds.
- R3: A strobe carrying code 5, 6 or 7 leaves the input level and the timer unchanged.
- R4: After the last accepted strobe, input level stays put through TIMEOUT_S-1 ticks and returns to 5 in the cycle after the TIMEOUT_S-th tick.
- R5: When an accepted strobe and a tick arrive in the same cycle, the strobe wins: the timer restarts at TIMEOUT_S and the tick is not counted.
- R6: A port with sync_en_i low has input level 5 from the next cycle on, and its strobes are ignored.
- R7: elig_o of a port is high exactly when its sync_en_i is high and its input level is 0 to 3; the Unknown (5) and Do-Not-Use (4) levels are ineligible.
- R8: upd_o of a port is high for one cycle, in the first cycle that shows a new input level, and stays low when a strobe repeats the current level.
- R9: With ref_from_port_i high and ref_port_i naming port k, port k transmits 4 and every other port transmits sys_ql_i, one cycle after the inputs.
- R10: With ref_from_port_i low, every port transmits sys_ql_i one cycle later.
- R11: With ref_from_port_i high and ref_port_i not below NUM_PORTS, every port transmits sys_ql_i one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_en_i | input | NUM_PORTS | Synchronous-mode enable per port |
| rx_vld_i | input | NUM_PORTS | Received-code strobe per port |
| rx_ql_i | input | NUM_PORTS*3 | Received code per port, port p in bits [3p+2:3p] |
| tick_1s_i | input | 1 | One-cycle pulse once per second |
| sys_ql_i | input | 3 | System clock quality level |
| ref_from_port_i | input | 1 | High when the system reference comes from a port |
| ref_port_i | input | PORT_W | Index of the reference port |
| in_ql_o | output | NUM_PORTS*3 | Input level per port, same packing as rx_ql_i |
| elig_o | output | NUM_PORTS | Port may serve as line clock input |
| upd_o | output | NUM_PORTS | One-cycle pulse on an input level change |
| tx_ql_o | output | NUM_PORTS*3 | Level to transmit per port, same packing |

## Verification
A usable strobe and the one-second tick can land in the same cycle on a port. The timer must then restart instead of counting down. This matters most when the timer holds one second, where a counted tick would expire the level at once.

The bench provokes this directly by pairing a strobe with a tick after three idle ticks. It then counts ticks until expiry.

Random traffic adds many further overlaps, each judged cycle by cycle against a bench model of level and timer. A sync-enable drop on a port that is strobed in the same cycle is also judged this way, since the drop must win.

// File: rtl/synce_ql_pkg.sv
package synce_ql_pkg;
  localparam int QL_W = 3;
  typedef logic [QL_W-1:0] ql_t;

  localparam ql_t QL_PRC  = 3'd0;
  localparam ql_t QL_SSUA = 3'd1;
  localparam ql_t QL_SSUB = 3'd2;
  localparam ql_t QL_SEC  = 3'd3;
  localparam ql_t QL_DNU  = 3'd4;
  localparam ql_t QL_UNK  = 3'd5;

  // codes that replace the stored input level
  function automatic logic ql_accept(ql_t q);
    return q <= QL_DNU;
  endfunction

  // codes a line clock input may carry
  function automatic logic ql_traceable(ql_t q);
    return q <= QL_SEC;
  endfunction
endpackage

// File: rtl/ql_rx_port.sv
module ql_rx_port
  import synce_ql_pkg::*;
#(
  parameter int TIMEOUT_S = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_en_i,
  input  logic rx_vld_i,
  input  ql_t  rx_ql_i,
  input  logic tick_i,
  output ql_t  ql_o,
  output logic upd_o,
  output logic elig_o
);
  localparam int CNT_W = $clog2(TIMEOUT_S + 1);

  ql_t              ql_q, ql_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_q;
  logic             take;

  assign take = rx_vld_i && ql_accept(rx_ql_i);

  always_comb begin
    ql_d  = ql_q;
    cnt_d = cnt_q;
    if (!sync_en_i) begin
      ql_d  = QL_UNK;
      cnt_d = '0;
    end else if (take) begin
      ql_d  = rx_ql_i;
      cnt_d = CNT_W'(TIMEOUT_S);
    end else if (tick_i && cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) ql_d = QL_UNK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ql_q  <= QL_UNK;
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else begin
      ql_q  <= ql_d;
      cnt_q <= cnt_d;
      upd_q <= (ql_d != ql_q);
    end
  end

  assign ql_o   = ql_q;
  assign upd_o  = upd_q;
  assign elig_o = sync_en_i && ql_traceable(ql_q);

  // R2
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_en_i && take |=> ql_q == $past(rx_ql_i) && cnt_q == CNT_W'(TIMEOUT_S));

  // R3
  ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_en_i && !take && !(tick_i && cnt_q == CNT_W'(1)) |=> $stable(ql_q));

  // R4
  expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_en_i && !take && tick_i && cnt_q == CNT_W'(1) |=> ql_q == QL_UNK);

  // R4
  idle_unk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) == (ql_q == QL_UNK));

  // R5
  strobe_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_en_i && take && tick_i |=> cnt_q == CNT_W'(TIMEOUT_S));

  // R6
  nosync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_en_i |=> ql_q == QL_UNK);

  // R8
  upd_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ql_q != $past(ql_q) |-> upd_o);

  // R8
  upd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ql_q == $past(ql_q) |-> !upd_o);
endmodule

// File: rtl/ql_tx_map.sv
module ql_tx_map
  import synce_ql_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int PORT_W    = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  ql_t                       sys_ql_i,
  input  logic                      ref_from_port_i,
  input  logic [PORT_W-1:0]         ref_port_i,
  output logic [NUM_PORTS*QL_W-1:0] tx_ql_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_tx
    ql_t  tx_q;
    logic is_ref;

    assign is_ref = ref_from_port_i && (ref_port_i == PORT_W'(p));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tx_q <= QL_DNU;
      else         tx_q <= is_ref ? QL_DNU : sys_ql_i;
    end

    assign tx_ql_o[p*QL_W +: QL_W] = tx_q;

    // R9
    loop_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ref_from_port_i && ref_port_i == PORT_W'(p) |=> tx_ql_o[p*QL_W +: QL_W] == QL_DNU);

    // R10
    follow_sys_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ref_from_port_i |=> tx_ql_o[p*QL_W +: QL_W] == $past(sys_ql_i));
  end
endmodule

// File: rtl/synce_ql_tracker.sv
module synce_ql_tracker
  import synce_ql_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int TIMEOUT_S = 5,
  parameter int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_PORTS-1:0]      sync_en_i,
  input  logic [NUM_PORTS-1:0]      rx_vld_i,
  input  logic [NUM_PORTS*QL_W-1:0] rx_ql_i,
  input  logic                      tick_1s_i,
  input  logic [QL_W-1:0]           sys_ql_i,
  input  logic                      ref_from_port_i,
  input  logic [PORT_W-1:0]         ref_port_i,
  output logic [NUM_PORTS*QL_W-1:0] in_ql_o,
  output logic [NUM_PORTS-1:0]      elig_o,
  output logic [NUM_PORTS-1:0]      upd_o,
  output logic [NUM_PORTS*QL_W-1:0] tx_ql_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    ql_t ql;

    ql_rx_port #(.TIMEOUT_S(TIMEOUT_S)) i_rx (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sync_en_i(sync_en_i[p]),
      .rx_vld_i (rx_vld_i[p]),
      .rx_ql_i  (rx_ql_i[p*QL_W +: QL_W]),
      .tick_i   (tick_1s_i),
      .ql_o     (ql),
      .upd_o    (upd_o[p]),
      .elig_o   (elig_o[p])
    );

    assign in_ql_o[p*QL_W +: QL_W] = ql;

    // R7
    elig_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      elig_o[p] |-> in_ql_o[p*QL_W +: QL_W] != QL_UNK && in_ql_o[p*QL_W +: QL_W] != QL_DNU);
  end

  ql_tx_map #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) i_tx (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sys_ql_i       (sys_ql_i),
    .ref_from_port_i(ref_from_port_i),
    .ref_port_i     (ref_port_i),
    .tx_ql_o        (tx_ql_o)
  );
endmodule

// File: tb/test_synce_ql_tracker.sv
module test_synce_ql_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 6;
  localparam int TO = 5;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NP-1:0]   d_sync = '0, d_vld = '0;
  logic [2:0]      d_code [NP];
  logic            d_tick = 1'b0;
  logic [2:0]      d_sys = 3'd0;
  logic            d_rfp = 1'b0;
  logic [PW-1:0]   d_ridx = '0;
  logic [NP*3-1:0] rx_flat;
  logic [NP*3-1:0] in_ql_o, tx_ql_o;
  logic [NP-1:0]   elig_o, upd_o;

  always_comb for (int p = 0; p < NP; p++) rx_flat[p*3 +: 3] = d_code[p];

  synce_ql_tracker #(.NUM_PORTS(NP), .TIMEOUT_S(TO)) i_synce_ql_tracker (
    .clk_i(clk), .rst_ni(rst_ni), .sync_en_i(d_sync), .rx_vld_i(d_vld),
    .rx_ql_i(rx_flat), .tick_1s_i(d_tick), .sys_ql_i(d_sys),
    .ref_from_port_i(d_rfp), .ref_port_i(d_ridx),
    .in_ql_o(in_ql_o), .elig_o(elig_o), .upd_o(upd_o), .tx_ql_o(tx_ql_o));

  int checks = 0, fails = 0;
  bit done = 0;
  int m_lvl [NP], m_cnt [NP], m_tx [NP];
  bit m_upd [NP];

  task automatic check(string req, int port, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s port %0d actual=%0d expected=%0d", req, port, act, exp);
    end
  endtask

  function automatic int lvl(int p); return int'(in_ql_o[p*3 +: 3]); endfunction
  function automatic int txl(int p); return int'(tx_ql_o[p*3 +: 3]); endfunction

  task automatic step();
    for (int p = 0; p < NP; p++) begin
      int old = m_lvl[p];
      if (!d_sync[p]) begin m_lvl[p] = 5; m_cnt[p] = 0; end
      else if (d_vld[p] && d_code[p] <= 3'd4) begin m_lvl[p] = int'(d_code[p]); m_cnt[p] = TO; end
      else if (d_tick && m_cnt[p] != 0) begin
        m_cnt[p]--;
        if (m_cnt[p] == 0) m_lvl[p] = 5;
      end
      m_upd[p] = (m_lvl[p] != old);
      m_tx[p] = (d_rfp && int'(d_ridx) == p) ? 4 : int'(d_sys);
    end
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      check("R2/R3/R4/R5/R6 level", p, lvl(p), m_lvl[p]);
      check("R7 elig", p, int'(elig_o[p]), int'(d_sync[p] && m_lvl[p] <= 3));
      check("R8 upd", p, int'(upd_o[p]), int'(m_upd[p]));
      check("R9/R10/R11 tx", p, txl(p), m_tx[p]);
    end
    d_vld = '0;
    d_tick = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin d_tick = 1'b1; step(); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int p = 0; p < NP; p++) begin
      d_code[p] = 3'd0; m_lvl[p] = 5; m_cnt[p] = 0; m_upd[p] = 0; m_tx[p] = 4;
    end
    repeat (3) @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      check("R1 reset level", p, lvl(p), 5);
      check("R1 reset elig", p, int'(elig_o[p]), 0);
      check("R1 reset upd", p, int'(upd_o[p]), 0);
      check("R1 reset tx", p, txl(p), 4);
    end
    rst_ni = 1'b1;
    d_sync = '1;
    step();

    // R2 / R3
    d_vld[0] = 1; d_code[0] = 3'd3;
    d_vld[1] = 1; d_code[1] = 3'd6;
    step();
    check("R2", 0, lvl(0), 3);
    check("R3", 1, lvl(1), 5);
    check("R8", 0, int'(upd_o[0]), 1);
    step();
    check("R8", 0, int'(upd_o[0]), 0);

    // R4 expiry exactly at the TO-th tick
    ticks(TO - 1);
    check("R4", 0, lvl(0), 3);
    ticks(1);
    check("R4", 0, lvl(0), 5);
    check("R8", 0, int'(upd_o[0]), 1);

    // R5 strobe and tick together
    d_vld[2] = 1; d_code[2] = 3'd0; step();
    ticks(3);
    d_vld[2] = 1; d_code[2] = 3'd0; d_tick = 1; step();
    ticks(TO - 1);
    check("R5", 2, lvl(2), 0);
    ticks(1);
    check("R5", 2, lvl(2), 5);

    // R8 repeated level, R7 eligibility
    d_vld[3] = 1; d_code[3] = 3'd2; step();
    d_vld[3] = 1; d_code[3] = 3'd2; step();
    check("R8", 3, int'(upd_o[3]), 0);
    check("R7", 3, int'(elig_o[3]), 1);
    d_vld[4] = 1; d_code[4] = 3'd4; step();
    check("R2", 4, lvl(4), 4);
    check("R7", 4, int'(elig_o[4]), 0);

    // R6 sync drop
    d_sync[3] = 0; step();
    check("R6", 3, lvl(3), 5);
    check("R7", 3, int'(elig_o[3]), 0);
    d_vld[3] = 1; d_code[3] = 3'd1; step();
    check("R6", 3, lvl(3), 5);
    d_sync[3] = 1;

    // R9 / R10 / R11
    d_sys = 3'd2; d_rfp = 1; d_ridx = 3'd1; step();
    check("R9", 1, txl(1), 4);
    check("R9", 0, txl(0), 2);
    d_rfp = 0; step();
    check("R10", 1, txl(1), 2);
    d_rfp = 1; d_ridx = 3'd7; step();
    for (int p = 0; p < NP; p++) check("R11", p, txl(p), 2);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      for (int p = 0; p < NP; p++) begin
        if (($urandom % 64) == 0) d_sync[p] = ~d_sync[p];
        d_vld[p] = (($urandom % 7) == 0);
        d_code[p] = 3'($urandom % 8);
      end
      d_tick = (($urandom % 3) == 0);
      if (($urandom % 8) == 0) d_sys = 3'($urandom % 6);
      d_rfp = ($urandom % 4) != 0;
      d_ridx = PW'($urandom % 8);
      step();
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule